// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one stored numeric operand, in any of six storage formats, and rewrites it in a single internal extended form. That form has a sign bit, a 16-bit exponent with bias 0x3FFF, and a 64-bit significand with an explicit leading bit. It also gives a two-bit class for the operand: normal, zero, infinity or NaN. The arithmetic stages that follow need only this one representation, whatever the operand was stored as.

The operand comes in on an 80-bit bus together with a 3-bit format code and a valid strobe. Integers, subnormal floats and extended values whose leading bit is clear are normalized in the same cycle by a combinational leading-zero counter. The result goes into registers and appears one clock after the strobe. Two flags come with the result. One marks an operand that was stored unnormalized. The other marks a signaling NaN, which the block turns into a quiet NaN on the way in.

The exponent output is a two's-complement 16-bit value. Only an extended operand with a small exponent and a clear leading bit can drive it below zero.

Top module: `fp_operand_unpacker`

## Requirements
- R1: `in_fmt` picks how the operand is unpacked.
  - 0 selects 80-bit extended: sign in bit 79, exponent in bits 78:64, significand in bits 63:0.
  - 1 selects double, in bits 63:0.
  - 2 selects single, in bits 31:0.
  - 4 selects a 16-bit integer, in bits 15:0.
  - 5 selects a 32-bit integer, in bits 31:0.
  - 6 selects a 64-bit two's-complement integer, in bits 63:0.
  - Codes 3 and 7 are handled as extended.
  - Bus bits outside the selected field have no effect.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. The result outputs change only in the cycle after `in_valid`, and otherwise hold their value.
- R3: A nonzero integer is unpacked in four steps.
  - The sign is taken from its top bit.
  - The magnitude is left-aligned in the 64-bit significand.
  - The exponent starts at 0x400E (16-bit), 0x401E (32-bit) or 0x403E (64-bit).
  - Each leading zero shifted out lowers the exponent by one.
  - The unnormal and invalid flags stay low.
- R4: An integer of value zero gives class 01 (zero), sign 0, exponent 0 and significand 0.
- R5: The 64-bit integer pattern 0x8000000000000000 gives a quiet NaN with the following fields.
  - Class 11, sign 0, exponent 0x7FFF.
  - `COMP_NAN_CODE` in significand bits 55:48, bit 62 set, and every other bit clear.
  - The invalid flag stays low.
- R6: A single with exponent field 1 to 0xFE gives exponent field + 0x3F80. The significand is {1, fraction, 40 zeros} and the class is 00.
- R7: A double with exponent field 1 to 0x7FE gives exponent field + 0x3C00. The significand is {1, fraction, 11 zeros} and the class is 00.
- R8: A single or double with exponent field 0 is handled as follows.
  - With a nonzero fraction, it starts at exponent 0x3F81 (single) or 0x3C01 (double) and is normalized, and the unnormal flag is raised.
  - With a zero fraction, it gives class 01 with exponent 0, significand 0 and its own sign.
- R9: An extended operand that is not at the maximum exponent is handled by its significand.
  - If significand bit 63 is set, it passes through unchanged.
  - If the significand is zero, it gives class 01 with exponent 0 and its own sign.
  - Otherwise it is shifted left until bit 63 is set, with the exponent lowered by one per shift, and the unnormal flag is raised.
- R10: An all-ones exponent field (0xFF, 0x7FF or 0x7FFF) whose fraction is zero gives class 10 (infinity) with exponent 0x7FFF, significand 0 and its own sign. The extended integer bit is ignored.
- R11: An all-ones exponent field whose fraction is nonzero gives a NaN with these fields.
  - Class 11 and exponent 0x7FFF.
  - The fraction aligned as in R6, R7 and R9, with bit 63 clear and bit 62 (the quiet bit) forced to 1.
  - `out_invalid` is high exactly when bit 62 was clear on input.
- R12: While reset is held, `out_valid` is low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_fmt | input | 3 | Storage format code |
| in_data | input | 80 | Operand bits, right-aligned per format |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Result sign |
| out_exp | output | 16 | Biased exponent, two's complement |
| out_sig | output | 64 | Significand with explicit leading bit |
| out_class | output | 2 | 00 normal, 01 zero, 10 infinity, 11 NaN |
| out_unnormal | output | 1 | Operand was stored unnormalized |
| out_invalid | output | 1 | Operand was a signaling NaN |

## Verification
Every result field and both flags are due exactly one clock edge after the strobe, because a single register stage sits between the inputs and the outputs. The bench drives each operand on a falling edge and lets one rising edge pass. It compares all fields on the next falling edge, so every sample lands in the cycle where the result is due. The hold checks drop the strobe, change the bus, and sample one edge later: `out_valid` must be low and the previous result must be unchanged.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

  localparam int SIG_W  = 64;
  localparam int EXP_W  = 16;
  localparam int BUS_W  = 80;
  localparam int SHF_W  = $clog2(SIG_W) + 1;

  localparam logic [EXP_W-1:0] EXP_MAX   = 16'h7FFF;
  localparam logic [EXP_W-1:0] SGL_BIAS  = 16'h3F80;
  localparam logic [EXP_W-1:0] DBL_BIAS  = 16'h3C00;
  localparam logic [EXP_W-1:0] I16_BASE  = 16'h400E;
  localparam logic [EXP_W-1:0] I32_BASE  = 16'h401E;
  localparam logic [EXP_W-1:0] C64_BASE  = 16'h403E;
  localparam logic [SIG_W-1:0] C64_NAN_PAT = 64'h8000_0000_0000_0000;

  typedef enum logic [2:0] {
    FMT_EXT = 3'd0, FMT_DBL = 3'd1, FMT_SGL = 3'd2, FMT_BAD = 3'd3,
    FMT_I16 = 3'd4, FMT_I32 = 3'd5, FMT_C64 = 3'd6, FMT_RSV = 3'd7
  } fmt_e;

  typedef enum logic [1:0] {
    CLS_NORM = 2'b00, CLS_ZERO = 2'b01, CLS_INF = 2'b10, CLS_NAN = 2'b11
  } cls_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    cls_e             cls;
    logic             unnormal;
    logic             invalid;
    logic             need_norm;
  } unpk_t;

  // Zero of a given sign.
  function automatic unpk_t f_zero(input logic s);
    unpk_t r;
    r = '0;
    r.sign = s;
    r.cls  = CLS_ZERO;
    return r;
  endfunction

  // Maximum-exponent operand: frac excludes any integer bit.
  function automatic unpk_t f_special(input logic s, input logic [SIG_W-2:0] frac);
    unpk_t r;
    r = '0;
    r.sign = s;
    r.exp  = EXP_MAX;
    if (frac == '0) begin
      r.cls = CLS_INF;
    end else begin
      r.cls     = CLS_NAN;
      r.sig     = {1'b0, 1'b1, frac[SIG_W-3:0]};
      r.invalid = ~frac[SIG_W-2];
    end
    return r;
  endfunction

  // Magnitude of a left-aligned two's-complement value.
  function automatic logic [SIG_W-1:0] f_mag(input logic [SIG_W-1:0] v);
    return v[SIG_W-1] ? (~v + 1'b1) : v;
  endfunction

endpackage

// File: rtl/fpu_lzc.sv
module fpu_lzc #(
  parameter int W     = 64,
  parameter int CHUNK = 8,
  localparam int NCH  = W / CHUNK,
  localparam int CHW  = $clog2(CHUNK),
  localparam int CW   = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  function automatic logic [CHW-1:0] f_chunk_lz(input logic [CHUNK-1:0] b);
    logic [CHW-1:0] n;
    logic           hit;
    n   = '0;
    hit = 1'b0;
    for (int k = CHUNK - 1; k >= 0; k--) begin
      if (!hit && b[k]) begin
        n   = CHW'(CHUNK - 1 - k);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic [NCH-1:0] nz;
  logic [CHW-1:0] lc [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [CHUNK-1:0] bits;
    assign bits  = vec[W-1-g*CHUNK -: CHUNK];
    assign nz[g] = |bits;
    assign lc[g] = f_chunk_lz(bits);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    cnt   = CW'(W);
    for (int i = 0; i < NCH; i++) begin
      if (!found && nz[i]) begin
        cnt   = CW'(i * CHUNK) + CW'(lc[i]);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpu_unpack_field.sv
module fpu_unpack_field
  import fpu_unpack_pkg::*;
#(
  parameter logic [7:0] COMP_NAN_CODE = 8'h14
) (
  input  logic [2:0]       fmt,
  input  logic [BUS_W-1:0] data,
  output unpk_t            raw
);

  logic [7:0]       e8;
  logic [22:0]      f23;
  logic [10:0]      e11;
  logic [51:0]      f52;
  logic [14:0]      e15;
  logic [SIG_W-1:0] s64;
  logic [SIG_W-1:0] int_al;
  logic [EXP_W-1:0] int_base;

  assign e8  = data[30:23];
  assign f23 = data[22:0];
  assign e11 = data[62:52];
  assign f52 = data[51:0];
  assign e15 = data[78:64];
  assign s64 = data[63:0];

  always_comb begin
    case (fmt)
      FMT_I16: begin int_al = {data[15:0], 48'b0}; int_base = I16_BASE; end
      FMT_I32: begin int_al = {data[31:0], 32'b0}; int_base = I32_BASE; end
      default: begin int_al = data[63:0];          int_base = C64_BASE; end
    endcase
  end

  always_comb begin
    raw = '0;
    case (fmt)
      FMT_SGL: begin
        if (e8 == '1) begin
          raw = f_special(data[31], {f23, 40'b0});
        end else if (e8 == '0) begin
          if (f23 == '0) raw = f_zero(data[31]);
          else begin
            raw.sign      = data[31];
            raw.exp       = SGL_BIAS + 16'd1;
            raw.sig       = {1'b0, f23, 40'b0};
            raw.need_norm = 1'b1;
            raw.unnormal  = 1'b1;
          end
        end else begin
          raw.sign = data[31];
          raw.exp  = SGL_BIAS + {8'b0, e8};
          raw.sig  = {1'b1, f23, 40'b0};
        end
      end
      FMT_DBL: begin
        if (e11 == '1) begin
          raw = f_special(data[63], {f52, 11'b0});
        end else if (e11 == '0) begin
          if (f52 == '0) raw = f_zero(data[63]);
          else begin
            raw.sign      = data[63];
            raw.exp       = DBL_BIAS + 16'd1;
            raw.sig       = {1'b0, f52, 11'b0};
            raw.need_norm = 1'b1;
            raw.unnormal  = 1'b1;
          end
        end else begin
          raw.sign = data[63];
          raw.exp  = DBL_BIAS + {5'b0, e11};
          raw.sig  = {1'b1, f52, 11'b0};
        end
      end
      FMT_I16, FMT_I32, FMT_C64: begin
        if (fmt == FMT_C64 && int_al == C64_NAN_PAT) begin
          raw.exp = EXP_MAX;
          raw.cls = CLS_NAN;
          raw.sig = {2'b01, 6'b0, COMP_NAN_CODE, 48'b0};
        end else if (int_al == '0) begin
          raw = f_zero(1'b0);
        end else begin
          raw.sign      = int_al[SIG_W-1];
          raw.exp       = int_base;
          raw.sig       = f_mag(int_al);
          raw.need_norm = 1'b1;
        end
      end
      default: begin
        if (e15 == '1) begin
          raw = f_special(data[79], s64[62:0]);
        end else if (s64[63]) begin
          raw.sign = data[79];
          raw.exp  = {1'b0, e15};
          raw.sig  = s64;
        end else if (s64 == '0) begin
          raw = f_zero(data[79]);
        end else begin
          raw.sign      = data[79];
          raw.exp       = {1'b0, e15};
          raw.sig       = s64;
          raw.need_norm = 1'b1;
          raw.unnormal  = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/fpu_unpack_norm.sv
module fpu_unpack_norm
  import fpu_unpack_pkg::*;
(
  input  unpk_t            raw,
  output unpk_t            fin,
  output logic [SHF_W-1:0] shift
);

  logic [SHF_W-1:0] lz;

  fpu_lzc #(.W(SIG_W), .CHUNK(8)) u_lzc (
    .vec (raw.sig),
    .cnt (lz)
  );

  assign shift = raw.need_norm ? lz : '0;

  always_comb begin
    fin     = raw;
    fin.sig = raw.sig << shift;
    fin.exp = raw.exp - EXP_W'(shift);
  end

endmodule

// File: rtl/fp_operand_unpacker.sv
module fp_operand_unpacker
  import fpu_unpack_pkg::*;
#(
  parameter logic [7:0] COMP_NAN_CODE = 8'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  in_fmt,
  input  logic [79:0] in_data,
  output logic        out_valid,
  output logic        out_sign,
  output logic [15:0] out_exp,
  output logic [63:0] out_sig,
  output logic [1:0]  out_class,
  output logic        out_unnormal,
  output logic        out_invalid
);

  unpk_t            dec_raw;
  unpk_t            norm_res;
  logic [SHF_W-1:0] norm_shift;
  logic             dec_need_norm;

  fpu_unpack_field #(.COMP_NAN_CODE(COMP_NAN_CODE)) u_field (
    .fmt  (in_fmt),
    .data (in_data),
    .raw  (dec_raw)
  );

  fpu_unpack_norm u_norm (
    .raw   (dec_raw),
    .fin   (norm_res),
    .shift (norm_shift)
  );

  assign dec_need_norm = dec_raw.need_norm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sign     <= 1'b0;
      out_exp      <= '0;
      out_sig      <= '0;
      out_class    <= '0;
      out_unnormal <= 1'b0;
      out_invalid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign     <= norm_res.sign;
        out_exp      <= norm_res.exp;
        out_sig      <= norm_res.sig;
        out_class    <= norm_res.cls;
        out_unnormal <= norm_res.unnormal;
        out_invalid  <= norm_res.invalid;
      end
    end
  end

endmodule

// File: rtl/fp_unpacker_checks.sv
module fp_unpacker_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_fmt,
  input logic        dec_need_norm,
  input logic        out_valid,
  input logic [15:0] out_exp,
  input logic [63:0] out_sig,
  input logic [1:0]  out_class,
  input logic        out_unnormal,
  input logic        out_invalid
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sig) && $stable(out_exp) && $stable(out_class)));

  a_r9_normal_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'b00) |-> out_sig[63]);

  a_r4_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'b01) |-> (out_exp == 16'h0 && out_sig == 64'h0));

  a_r10_inf_form: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'b10) |-> (out_exp == 16'h7FFF && out_sig == 64'h0));

  a_r11_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'b11) |-> (out_exp == 16'h7FFF && out_sig[62] && !out_sig[63]));

  a_r11_invalid_only_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_class == 2'b11);

  a_r8_unnormal_is_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unnormal) |-> out_class == 2'b00);

  a_r8_norm_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_need_norm) |=> out_sig[63]);

  a_r3_int_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt inside {3'd4, 3'd5, 3'd6}) |=> (!out_unnormal && !out_invalid));

endmodule

bind fp_operand_unpacker fp_unpacker_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_fmt        (in_fmt),
  .dec_need_norm (dec_need_norm),
  .out_valid     (out_valid),
  .out_exp       (out_exp),
  .out_sig       (out_sig),
  .out_class     (out_class),
  .out_unnormal  (out_unnormal),
  .out_invalid   (out_invalid)
);

// File: tb/fp_operand_unpacker_test.sv
`timescale 1ns/1ps
module fp_operand_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_fmt = '0;
  logic [79:0] in_data = '0;
  logic        out_valid, out_sign, out_unnormal, out_invalid;
  logic [15:0] out_exp;
  logic [63:0] out_sig;
  logic [1:0]  out_class;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fp_operand_unpacker #(.COMP_NAN_CODE(8'h14)) uut (
    .clk, .rst_n, .in_valid, .in_fmt, .in_data,
    .out_valid, .out_sign, .out_exp, .out_sig, .out_class,
    .out_unnormal, .out_invalid
  );

  // {fmt, data, sign, exp, sig, class, unnormal, invalid}
  localparam int NV = 27;
  localparam logic [167:0] VEC [NV] = '{
    {3'd2, 80'h0000_00000000_3F800000, 1'b0, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R6
    {3'd2, 80'h0000_00000000_C0200000, 1'b1, 16'h4000, 64'hA000000000000000, 2'd0, 1'b0, 1'b0}, // R6
    {3'd2, 80'h0000_00000000_00000001, 1'b0, 16'h3F6A, 64'h8000000000000000, 2'd0, 1'b1, 1'b0}, // R8
    {3'd2, 80'h0000_00000000_80000000, 1'b1, 16'h0000, 64'h0000000000000000, 2'd1, 1'b0, 1'b0}, // R8
    {3'd2, 80'h0000_00000000_7F800000, 1'b0, 16'h7FFF, 64'h0000000000000000, 2'd2, 1'b0, 1'b0}, // R10
    {3'd2, 80'h0000_00000000_7F800001, 1'b0, 16'h7FFF, 64'h4000010000000000, 2'd3, 1'b0, 1'b1}, // R11
    {3'd2, 80'h0000_00000000_FFC00000, 1'b1, 16'h7FFF, 64'h4000000000000000, 2'd3, 1'b0, 1'b0}, // R11
    {3'd1, 80'h0000_3FF00000_00000000, 1'b0, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R7
    {3'd1, 80'h0000_00000000_00000001, 1'b0, 16'h3BCD, 64'h8000000000000000, 2'd0, 1'b1, 1'b0}, // R8
    {3'd1, 80'h0000_FFF00000_00000000, 1'b1, 16'h7FFF, 64'h0000000000000000, 2'd2, 1'b0, 1'b0}, // R10
    {3'd0, 80'h3FFF_80000000_00000000, 1'b0, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R9
    {3'd0, 80'h4000_00000000_00000003, 1'b0, 16'h3FC2, 64'hC000000000000000, 2'd0, 1'b1, 1'b0}, // R9
    {3'd0, 80'h9234_00000000_00000000, 1'b1, 16'h0000, 64'h0000000000000000, 2'd1, 1'b0, 1'b0}, // R9
    {3'd0, 80'h7FFF_80000000_00000000, 1'b0, 16'h7FFF, 64'h0000000000000000, 2'd2, 1'b0, 1'b0}, // R10
    {3'd0, 80'h7FFF_80000000_00000005, 1'b0, 16'h7FFF, 64'h4000000000000005, 2'd3, 1'b0, 1'b1}, // R11
    {3'd3, 80'h3FFF_80000000_00000000, 1'b0, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R1
    {3'd4, 80'h0000_00000000_00000001, 1'b0, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd4, 80'h0000_00000000_00008000, 1'b1, 16'h400E, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd4, 80'h0000_00000000_0000FFFD, 1'b1, 16'h4000, 64'hC000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd4, 80'h0000_00000000_00000000, 1'b0, 16'h0000, 64'h0000000000000000, 2'd1, 1'b0, 1'b0}, // R4
    {3'd5, 80'h0000_00000000_7FFFFFFF, 1'b0, 16'h401D, 64'hFFFFFFFE00000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd5, 80'h0000_00000000_FFFFFFFF, 1'b1, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd6, 80'h0000_80000000_00000000, 1'b0, 16'h7FFF, 64'h4014000000000000, 2'd3, 1'b0, 1'b0}, // R5
    {3'd6, 80'h0000_FFFFFFFF_FFFFFFFF, 1'b1, 16'h3FFF, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd6, 80'h0000_00000001_00000000, 1'b0, 16'h401F, 64'h8000000000000000, 2'd0, 1'b0, 1'b0}, // R3
    {3'd6, 80'h0000_00000000_00000000, 1'b0, 16'h0000, 64'h0000000000000000, 2'd1, 1'b0, 1'b0}, // R4
    {3'd5, 80'hABCD_12345678_00000005, 1'b0, 16'h4001, 64'hA000000000000000, 2'd0, 1'b0, 1'b0}  // R1
  };

  function automatic string req_of(input int idx);
    case (idx)
      0, 1:                       return "R6";
      2, 3, 8:                    return "R8";
      4, 9, 13:                   return "R10";
      5, 6, 14:                   return "R11";
      7:                          return "R7";
      10, 11, 12:                 return "R9";
      15, 26:                     return "R1";
      19, 25:                     return "R4";
      22:                         return "R5";
      default:                    return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [87:0] got, input logic [87:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [87:0] result_now();
    return {out_valid, out_sign, out_exp, out_sig, out_class, out_unnormal, out_invalid, 2'b00};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", result_now(), 88'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", {87'b0, out_valid}, 88'h0);

    for (int i = 0; i < NV; i++) begin
      in_fmt   = VEC[i][167:165];
      in_data  = VEC[i][164:85];
      in_valid = 1'b1;
      @(negedge clk);
      check(req_of(i), result_now(), {1'b1, VEC[i][84:0], 2'b00});
    end

    // R2: strobe dropped, bus changed; result held, valid low
    in_valid = 1'b0;
    in_fmt   = 3'd2;
    in_data  = 80'h0000_00000000_3F800000;
    @(negedge clk);
    check("R2", result_now(),
          {1'b0, 1'b0, 16'h4001, 64'hA000000000000000, 2'd0, 1'b0, 1'b0, 2'b00});

    // R1: code 7 treated as extended, back-to-back strobes
    in_valid = 1'b1;
    in_fmt   = 3'd7;
    in_data  = 80'hC000_C0000000_00000000;
    @(negedge clk);
    check("R1", result_now(),
          {1'b1, 1'b1, 16'h4000, 64'hC000000000000000, 2'd0, 1'b0, 1'b0, 2'b00});
    in_fmt  = 3'd2;
    in_data = 80'hFFFF_FFFFFFFF_00000000;
    @(negedge clk);
    check("R1", result_now(),
          {1'b1, 1'b0, 16'h0000, 64'h0, 2'd1, 1'b0, 1'b0, 2'b00});
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {87'b0, out_valid}, 88'h0);

    // R12: reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", result_now(), 88'h0);
    finish_run();
  end

endmodule